// File: doc/BRIEF.md
# Operand-Size Resolution and Write Merge

This block sits between instruction decode and register write-back. For every decoded instruction it works out the effective operand width and address width. Legacy modes take a default from the code segment's size bit, and two separate per-instruction override prefixes can change it. In 64-bit mode a wide-operand prefix selects the operand width. Instruction forms that work on bytes are always 8 bits wide.

The block also merges an execution result into the old 64-bit value of the destination register. Only the bits that the resolved width may change are updated. Narrow writes keep the upper part of the old value. A 32-bit write in 64-bit mode clears the upper half.

The resolved widths are combinational and follow the current inputs. The merged register value and its write enable are registered and appear one clock after an input strobe.

Top module: `opsz_merge_top`

Width codes used on all size ports: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits, 2'b11 = 64 bits.

## Requirements
- R1: Outside 64-bit mode with no override, `op_size` and `addr_size` are both 2'b01 when `seg_dflt`=0 and both 2'b10 when `seg_dflt`=1.
- R2: Outside 64-bit mode, `opsz_ovr`=1 flips the operand width between 2'b01 and 2'b10 relative to the default, and leaves `addr_size` unchanged.
- R3: Outside 64-bit mode, `adsz_ovr`=1 flips the address width between 2'b01 and 2'b10 relative to the default, and leaves `op_size` unchanged.
- R4: When `byte_form`=1, `op_size` is 2'b00 in every mode, whatever the prefixes are.
- R5: In 64-bit mode (`long_mode`=1) with `byte_form`=0, `op_size` is 2'b11 when `wide_pfx`=1 and 2'b10 otherwise. `seg_dflt` and `opsz_ovr` have no effect on it.
- R6: In 64-bit mode, `addr_size` is 2'b11, or 2'b10 when `adsz_ovr`=1.
- R7: An 8-bit write takes bits [7:0] from `result` and keeps bits [63:8] of `dst_old`.
- R8: A 16-bit write takes bits [15:0] from `result` and keeps bits [63:16] of `dst_old`.
- R9: A 32-bit write takes bits [31:0] from `result`. Bits [63:32] keep `dst_old` outside 64-bit mode and are zero in 64-bit mode.
- R10: A 64-bit write copies all of `result`.
- R11: `wr_en` is high exactly one cycle after each cycle with `in_valid`=1, and `wr_data` then shows that input's merged value. With no strobe, `wr_en` is low and `wr_data` holds its value.
- R12: While reset is asserted, `wr_en` and `wr_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe marking a decoded instruction |
| seg_dflt | input | 1 | Default-size bit of the current code segment |
| opsz_ovr | input | 1 | Operand-size override prefix present |
| adsz_ovr | input | 1 | Address-size override prefix present |
| long_mode | input | 1 | 64-bit mode active |
| wide_pfx | input | 1 | Wide-operand prefix bit |
| byte_form | input | 1 | Instruction form works on bytes |
| dst_old | input | 64 | Current destination register value |
| result | input | 64 | Result to merge |
| op_size | output | 2 | Resolved operand width code |
| addr_size | output | 2 | Resolved address width code |
| wr_en | output | 1 | Registered write enable |
| wr_data | output | 64 | Registered merged register value |

## Verification
The two width codes are combinational, so the bench checks them in the same cycle the inputs are driven, shortly after each falling-edge drive. The merged value and write enable pass through one register. For each strobe the driver queues the expected value, and the monitor compares it a little after the next rising edge. In cycles with no strobe the monitor checks that `wr_en` is low and that `wr_data` still holds the last merged value. This way a late, early or missing write is reported as a mismatch.

// File: rtl/opsz_pkg.sv
package opsz_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_W = 2'b01,
    SZ_D = 2'b10,
    SZ_Q = 2'b11
  } size_e;
endpackage

// File: rtl/opsz_resolve.sv
module opsz_resolve
  import opsz_pkg::*;
(
  input  logic  seg_dflt,
  input  logic  opsz_ovr,
  input  logic  adsz_ovr,
  input  logic  long_mode,
  input  logic  wide_pfx,
  input  logic  byte_form,
  output size_e op_sz,
  output size_e ad_sz
);
  logic op_is_d;
  logic ad_is_d;

  // Each legacy override flips the width away from the segment default.
  always_comb begin
    op_is_d = seg_dflt ^ opsz_ovr;
    ad_is_d = seg_dflt ^ adsz_ovr;

    if (byte_form)      op_sz = SZ_B;
    else if (long_mode) op_sz = wide_pfx ? SZ_Q : SZ_D;
    else                op_sz = op_is_d ? SZ_D : SZ_W;

    if (long_mode)      ad_sz = adsz_ovr ? SZ_D : SZ_Q;
    else                ad_sz = ad_is_d ? SZ_D : SZ_W;
  end
endmodule

// File: rtl/opsz_write_merge.sv
module opsz_write_merge
  import opsz_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  size_e              sz,
  input  logic               long_mode,
  input  logic [DATA_W-1:0]  old_val,
  input  logic [DATA_W-1:0]  res_val,
  output logic [DATA_W-1:0]  merged
);
  localparam int NSZ = 4;

  // One replace mask per width code: width = 8 << code, capped at DATA_W.
  logic [DATA_W-1:0] lane_mask [NSZ];

  genvar g;
  generate
    for (g = 0; g < NSZ; g++) begin : g_mask
      localparam int LW = ((8 << g) > DATA_W) ? DATA_W : (8 << g);
      assign lane_mask[g] = (LW >= DATA_W) ? {DATA_W{1'b1}}
                                           : {{(DATA_W-LW){1'b0}}, {LW{1'b1}}};
    end
  endgenerate

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] repl_mask;

  always_comb begin
    repl_mask = lane_mask[sz];
    // A 32-bit write in 64-bit mode drops the old upper half.
    if (long_mode && (sz == SZ_D)) keep_mask = '0;
    else                           keep_mask = ~repl_mask;
    merged = (old_val & keep_mask) | (res_val & repl_mask);
  end
endmodule

// File: rtl/opsz_wb_reg.sv
module opsz_wb_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_in,
  output logic              en_q,
  output logic [DATA_W-1:0] d_q
);
  logic              en_nxt;
  logic [DATA_W-1:0] d_nxt;

  always_comb begin
    en_nxt = load;
    d_nxt  = load ? d_in : d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      d_q  <= '0;
    end else begin
      en_q <= en_nxt;
      d_q  <= d_nxt;
    end
  end
endmodule

// File: rtl/opsz_merge_top.sv
module opsz_merge_top
  import opsz_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              seg_dflt,
  input  logic              opsz_ovr,
  input  logic              adsz_ovr,
  input  logic              long_mode,
  input  logic              wide_pfx,
  input  logic              byte_form,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [DATA_W-1:0] result,
  output logic [1:0]        op_size,
  output logic [1:0]        addr_size,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  size_e             op_sz;
  size_e             ad_sz;
  logic [DATA_W-1:0] merged;

  opsz_resolve u_resolve (
    .seg_dflt  (seg_dflt),
    .opsz_ovr  (opsz_ovr),
    .adsz_ovr  (adsz_ovr),
    .long_mode (long_mode),
    .wide_pfx  (wide_pfx),
    .byte_form (byte_form),
    .op_sz     (op_sz),
    .ad_sz     (ad_sz)
  );

  opsz_write_merge #(.DATA_W(DATA_W)) u_merge (
    .sz        (op_sz),
    .long_mode (long_mode),
    .old_val   (dst_old),
    .res_val   (result),
    .merged    (merged)
  );

  opsz_wb_reg #(.DATA_W(DATA_W)) u_wb (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d_in  (merged),
    .en_q  (wr_en),
    .d_q   (wr_data)
  );

  assign op_size   = op_sz;
  assign addr_size = ad_sz;
endmodule

// File: rtl/opsz_merge_chk.sv
module opsz_merge_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              seg_dflt,
  input logic              opsz_ovr,
  input logic              adsz_ovr,
  input logic              long_mode,
  input logic              wide_pfx,
  input logic              byte_form,
  input logic [DATA_W-1:0] dst_old,
  input logic [DATA_W-1:0] result,
  input logic [1:0]        op_size,
  input logic [1:0]        addr_size,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data
);
  assert_byte_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_form |-> op_size == 2'b00);

  assert_q_only_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_size == 2'b11 |-> long_mode && wide_pfx);

  assert_addr_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
    long_mode |-> addr_size[1]);

  assert_byte_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && byte_form |=>
      wr_data[DATA_W-1:8] == $past(dst_old[DATA_W-1:8]) &&
      wr_data[7:0] == $past(result[7:0]));

  assert_zero_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && long_mode && !byte_form && !wide_pfx |=>
      wr_data[DATA_W-1:32] == '0);

  assert_full_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_size == 2'b11 |=> wr_data == $past(result));

  assert_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wr_en);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en && $stable(wr_data));
endmodule

bind opsz_merge_top opsz_merge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/opsz_merge_top_bench.sv
`timescale 1ns/1ps
module opsz_merge_top_bench;
  localparam int  DW = 64;
  localparam time HALF = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, seg_dflt, opsz_ovr, adsz_ovr, long_mode, wide_pfx, byte_form;
  logic [DW-1:0] dst_old, result;
  logic [1:0]    op_size, addr_size;
  logic          wr_en;
  logic [DW-1:0] wr_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] last_data;

  always #HALF clk = ~clk;

  opsz_merge_top u_opsz_merge_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_dflt(seg_dflt),
    .opsz_ovr(opsz_ovr), .adsz_ovr(adsz_ovr), .long_mode(long_mode),
    .wide_pfx(wide_pfx), .byte_form(byte_form), .dst_old(dst_old),
    .result(result), .op_size(op_size), .addr_size(addr_size),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected widths taken from the requirement text.
  function automatic logic [1:0] exp_op(bit sd, bit oo, bit lm, bit wp, bit bf);
    if (bf) return 2'b00;
    if (lm) return wp ? 2'b11 : 2'b10;
    return (sd ^ oo) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] exp_ad(bit sd, bit ao, bit lm);
    if (lm) return ao ? 2'b10 : 2'b11;
    return (sd ^ ao) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [DW-1:0] exp_wr(logic [1:0] sz, bit lm,
                                           logic [DW-1:0] o, logic [DW-1:0] r);
    case (sz)
      2'b00:   return {o[63:8], r[7:0]};
      2'b01:   return {o[63:16], r[15:0]};
      2'b10:   return lm ? {32'h0, r[31:0]} : {o[63:32], r[31:0]};
      default: return r;
    endcase
  endfunction

  function automatic string wr_tag(logic [1:0] sz);
    case (sz)
      2'b00:   return "R7";
      2'b01:   return "R8";
      2'b10:   return "R9";
      default: return "R10";
    endcase
  endfunction

  // Driver: one strobe cycle, width checks now, merge result queued.
  task automatic drive(bit sd, bit oo, bit ao, bit lm, bit wp, bit bf,
                       logic [DW-1:0] o, logic [DW-1:0] r);
    logic [1:0] eo, ea;
    string to, ta;
    @(negedge clk);
    in_valid = 1; seg_dflt = sd; opsz_ovr = oo; adsz_ovr = ao;
    long_mode = lm; wide_pfx = wp; byte_form = bf; dst_old = o; result = r;
    #1;
    eo = exp_op(sd, oo, lm, wp, bf);
    ea = exp_ad(sd, ao, lm);
    to = bf ? "R4" : (lm ? "R5" : (oo ? "R2" : "R1"));
    ta = lm ? "R6" : (ao ? "R3" : "R1");
    check(to, {62'h0, op_size}, {62'h0, eo});
    check(ta, {62'h0, addr_size}, {62'h0, ea});
    exp_q.push_back(exp_wr(eo, lm, o, r));
    tag_q.push_back(wr_tag(eo));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      dst_old = {$urandom, $urandom};
      result = {$urandom, $urandom};
    end
  endtask

  // Monitor: registered outputs are due one rising edge after the strobe.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          check("R11 unexpected write", {63'h0, wr_en}, 64'h0);
        end else begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " R11"}, wr_data, e);
        end
      end else begin
        check("R11 hold", wr_data, last_data);
      end
      last_data = wr_data;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; seg_dflt = 0; opsz_ovr = 0; adsz_ovr = 0;
    long_mode = 0; wide_pfx = 0; byte_form = 0;
    dst_old = 64'h1111_2222_3333_4444; result = 64'h5555_6666_7777_8888;
    repeat (3) @(posedge clk);
    #2;
    check("R12 wr_en", {63'h0, wr_en}, 64'h0);
    check("R12 wr_data", wr_data, 64'h0);
    last_data = '0;
    @(negedge clk); rst_n = 1;

    // Legacy defaults and overrides.
    drive(0, 0, 0, 0, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0123_4567_89AB_CDEF);
    drive(1, 0, 0, 0, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0123_4567_89AB_CDEF);
    drive(0, 1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    drive(1, 1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    drive(0, 0, 1, 0, 0, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(1, 0, 1, 0, 0, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(2);
    // Byte forms in both modes, even with wide prefix.
    drive(1, 0, 0, 0, 0, 1, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0);
    drive(0, 0, 0, 1, 1, 1, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0);
    // 64-bit mode: segment bit and operand override ignored.
    drive(0, 1, 0, 1, 0, 0, 64'hFFFF_FFFF_0000_0000, 64'hAAAA_AAAA_5555_5555);
    drive(1, 0, 1, 1, 0, 0, 64'hFFFF_FFFF_0000_0000, 64'hAAAA_AAAA_5555_5555);
    drive(0, 0, 0, 1, 1, 0, 64'h0, 64'h8000_0000_0000_0001);
    idle(3);

    for (int k = 0; k < 400; k++) begin
      logic [6:0] b;
      b = 7'($urandom);
      drive(b[0], b[1], b[2], b[3], b[4], b[5], {$urandom, $urandom}, {$urandom, $urandom});
      if (b[6]) idle(1 + ($urandom % 3));
    end
    idle(3);
    check("R11 pending", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(HALF * 2 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule